// File: doc/BRIEF.md
# Spindle Frequency Error PWM Detector

This block closes the main-servo speed loop of a constant-linear-velocity spindle. The playback frame clock is divided by four. Over a fixed gate of 1000 divided periods, the block counts ticks of a crystal-derived reference clock. When the spindle turns at the correct speed, that count is 1152. The difference from 1152 is limited to ±63 and kept as a 7-bit value: a brake flag plus a 6-bit magnitude. That value sets the duty of a three-level PWM output.

Both clocks reach the block as single-cycle enables of one system clock. The carrier period is 128 reference ticks, which is about 16 kHz at a 2.1168 MHz reference. At the start of each carrier period, the PWM drives one direction for `magnitude` reference ticks and then rests at the mid level for the rest of the period. A spindle running slow gets the high-drive (speed-up) level. A spindle running fast gets the low-drive (brake) level. When the error is zero, the output stays at the mid level.

The block works only while the mode enable selects main servo. When the enable is low, the block rests at the mid level and its measurement restarts from zero. The PWM is a four-state machine:
- **OFF**: disabled.
- **ACQUIRE**: first gate after enable, before any result exists.
- **MID**: resting at the mid level.
- **DRIVE**: driving in one direction.

Its transitions are:
- **enable**: OFF to ACQUIRE.
- **first result**: ACQUIRE to DRIVE or MID, at the first gate end.
- **period start**: MID to DRIVE or MID, on the 128th reference tick.
- **duty done**: DRIVE to MID, after `magnitude` ticks.
- **disable**: any state to OFF.

Top module: `spindle_afc`

## Requirements
- R1: The frame enable is divided by 4. A gate closes on every 4000th frame enable counted since the enable went high. The count taken includes any reference tick in the closing cycle.
- R2: A gate count of exactly 1152 gives a period with no drive: `idle` stays high on every reference tick of that period.
- R3: A count above 1152 (fast) drives `drive_lo` (brake) for exactly (count − 1152) reference ticks at the start of each carrier period. `drive_hi` stays low.
- R4: A count below 1152 (slow) drives `drive_hi` (speed-up) for exactly (1152 − count) reference ticks at the start of each carrier period. `drive_lo` stays low.
- R5: The error magnitude saturates at 63. Counts of 1215 and above give 63 brake ticks, and counts of 1089 and below give 63 speed-up ticks.
- R6: A carrier period is 128 reference ticks. The first period starts at the first gate end. The duty used for a period is taken only at its start, from the newest gate result, including a gate that closes in that same cycle.
- R7: From enable until the first gate end, the output is `idle`.
- R8: After a cycle with `en` low, the output is `idle` and the measurement restarts.
- R9: Exactly one of `drive_hi`, `drive_lo` and `idle` is high in every cycle.
- R10: While `rst_n` is low, `idle` is high and both drive outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Main-servo mode select; low forces OFF |
| frame_ce | input | 1 | One-cycle enable per playback frame clock edge |
| ref_ce | input | 1 | One-cycle enable per reference clock edge |
| drive_hi | output | 1 | Speed-up (high supply) level select |
| drive_lo | output | 1 | Brake (ground) level select |
| idle | output | 1 | Mid reference level select |

## Verification
The bench drives reference ticks spread evenly over each 4000-enable window, so that every gate holds an exact chosen count. It then compares the ticks in each carrier period, per direction, against the duty it expects. The corner cases are:
- **A count of exactly 1152.** A design that tested the sign wrongly would leak a one-tick pulse.
- **Counts one tick above and one tick below 1152.** A swapped brake/speed-up mapping would show up here.
- **The limit count 1215 and counts far beyond it on both sides.** Missing saturation would wrap the magnitude into a small or wrong duty.
- **A gate ending in the same cycle as a period start.** A design without forwarding would apply a stale duty for a whole period.
- **Dropping the enable during a drive, then enabling again.** This catches a design that keeps driving after disable, or that skips the acquire gate.

// File: rtl/spafc_pkg.sv
package spafc_pkg;

    // PWM controller states
    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_ACQUIRE = 2'd1,
        ST_MID     = 2'd2,
        ST_DRIVE   = 2'd3
    } pwm_state_e;

endpackage

// File: rtl/spafc_meas.sv
// Frame clock divider, gate timer and reference tick counter.
module spafc_meas #(
    parameter int FRAME_DIV = 4,
    parameter int GATE_LEN  = 1000,
    parameter int CNT_W     = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             frame_ce,
    input  logic             ref_ce,
    output logic             gate_end,
    output logic [CNT_W-1:0] meas_cnt
);

    localparam int DIV_W = (FRAME_DIV > 1) ? $clog2(FRAME_DIV) : 1;
    localparam int GATE_W = (GATE_LEN > 1) ? $clog2(GATE_LEN) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(FRAME_DIV - 1);
    localparam logic [GATE_W-1:0] GATE_LAST = GATE_W'(GATE_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [DIV_W-1:0]  div_q;
    logic [GATE_W-1:0] gate_q;
    logic [CNT_W-1:0]  ref_q;
    logic              div_tick;

    assign div_tick = en && frame_ce && (div_q == DIV_LAST);
    assign gate_end = div_tick && (gate_q == GATE_LAST);

    // count seen at the closing cycle includes that cycle's tick
    assign meas_cnt = (ref_ce && (ref_q != CNT_MAX)) ? ref_q + CNT_W'(1) : ref_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!en) begin
            div_q <= '0;
        end else if (frame_ce) begin
            div_q <= (div_q == DIV_LAST) ? '0 : div_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else if (!en) begin
            gate_q <= '0;
        end else if (div_tick) begin
            gate_q <= (gate_q == GATE_LAST) ? '0 : gate_q + GATE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q <= '0;
        end else if (!en || gate_end) begin
            ref_q <= '0;
        end else begin
            ref_q <= meas_cnt;
        end
    end

endmodule

// File: rtl/spafc_errmap.sv
// Maps a gate count to brake flag plus saturated magnitude.
module spafc_errmap #(
    parameter int CNT_W   = 12,
    parameter int NOMINAL = 1152,
    parameter int MAG_W   = 6
) (
    input  logic [CNT_W-1:0] meas_cnt,
    output logic             brake,
    output logic [MAG_W-1:0] mag
);

    localparam int EXT_W = CNT_W + 2;
    localparam logic [EXT_W-1:0] NOM_EXT = EXT_W'(NOMINAL);
    localparam logic [EXT_W-1:0] MAG_LIM = EXT_W'((2 ** MAG_W) - 1);

    logic signed [EXT_W-1:0] diff;
    logic [EXT_W-1:0]        abs_v;

    always_comb begin
        diff  = $signed({2'b00, meas_cnt}) - $signed(NOM_EXT);
        abs_v = diff[EXT_W-1] ? EXT_W'(-diff) : EXT_W'(diff);
        brake = !diff[EXT_W-1] && (diff != '0);
        if (abs_v > MAG_LIM) begin
            mag = MAG_LIM[MAG_W-1:0];
        end else begin
            mag = abs_v[MAG_W-1:0];
        end
    end

endmodule

// File: rtl/spafc_pwm_fsm.sv
// Three-level PWM controller on a carrier of 2**PWM_BITS reference ticks.
module spafc_pwm_fsm
    import spafc_pkg::*;
#(
    parameter int MAG_W    = 6,
    parameter int PWM_BITS = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             ref_ce,
    input  logic             gate_end,
    input  logic             new_brake,
    input  logic [MAG_W-1:0] new_mag,
    output logic             drive_hi,
    output logic             drive_lo,
    output logic             idle
);

    localparam logic [PWM_BITS-1:0] PC_LAST = '1;

    pwm_state_e          st_q, st_nxt;
    logic [PWM_BITS-1:0] pc_q;
    logic                duty_brake_q, per_brake_q;
    logic [MAG_W-1:0]    duty_mag_q, per_mag_q;
    logic                src_brake;
    logic [MAG_W-1:0]    src_mag;
    logic                period_wrap, duty_done, period_load;

    // newest result, forwarded when a gate closes this cycle
    assign src_brake   = gate_end ? new_brake : duty_brake_q;
    assign src_mag     = gate_end ? new_mag : duty_mag_q;
    assign period_wrap = ref_ce && (pc_q == PC_LAST);
    assign duty_done   = ref_ce && (pc_q == (PWM_BITS'(per_mag_q) - PWM_BITS'(1)));

    always_comb begin
        st_nxt      = st_q;
        period_load = 1'b0;
        unique case (st_q)
            ST_OFF: begin
                st_nxt = ST_ACQUIRE;
            end
            ST_ACQUIRE: begin
                if (gate_end) begin
                    period_load = 1'b1;
                    st_nxt = (src_mag != '0) ? ST_DRIVE : ST_MID;
                end
            end
            ST_MID: begin
                if (period_wrap) begin
                    period_load = 1'b1;
                    st_nxt = (src_mag != '0) ? ST_DRIVE : ST_MID;
                end
            end
            ST_DRIVE: begin
                if (duty_done) begin
                    st_nxt = ST_MID;
                end
            end
        endcase
        if (!en) begin
            st_nxt      = ST_OFF;
            period_load = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_OFF;
        end else begin
            st_q <= st_nxt;
        end
    end

    // carrier phase and duty holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q         <= '0;
            per_brake_q  <= 1'b0;
            per_mag_q    <= '0;
            duty_brake_q <= 1'b0;
            duty_mag_q   <= '0;
        end else if (!en) begin
            pc_q         <= '0;
            per_brake_q  <= 1'b0;
            per_mag_q    <= '0;
            duty_brake_q <= 1'b0;
            duty_mag_q   <= '0;
        end else begin
            if (gate_end) begin
                duty_brake_q <= new_brake;
                duty_mag_q   <= new_mag;
            end
            if (period_load) begin
                pc_q        <= '0;
                per_brake_q <= src_brake;
                per_mag_q   <= src_mag;
            end else if (ref_ce) begin
                pc_q <= pc_q + PWM_BITS'(1);
            end
        end
    end

    // outputs
    always_comb begin
        drive_hi = (st_q == ST_DRIVE) && !per_brake_q;
        drive_lo = (st_q == ST_DRIVE) && per_brake_q;
        idle     = (st_q != ST_DRIVE);
    end

endmodule

// File: rtl/spindle_afc.sv
module spindle_afc #(
    parameter int FRAME_DIV = 4,
    parameter int GATE_LEN  = 1000,
    parameter int NOMINAL   = 1152,
    parameter int MAG_W     = 6,
    parameter int PWM_BITS  = 7,
    parameter int CNT_W     = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic frame_ce,
    input  logic ref_ce,
    output logic drive_hi,
    output logic drive_lo,
    output logic idle
);

    logic             gate_end;
    logic [CNT_W-1:0] meas_cnt;
    logic             new_brake;
    logic [MAG_W-1:0] new_mag;

    spafc_meas #(
        .FRAME_DIV(FRAME_DIV),
        .GATE_LEN (GATE_LEN),
        .CNT_W    (CNT_W)
    ) u_meas (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .frame_ce(frame_ce),
        .ref_ce  (ref_ce),
        .gate_end(gate_end),
        .meas_cnt(meas_cnt)
    );

    spafc_errmap #(
        .CNT_W  (CNT_W),
        .NOMINAL(NOMINAL),
        .MAG_W  (MAG_W)
    ) u_errmap (
        .meas_cnt(meas_cnt),
        .brake   (new_brake),
        .mag     (new_mag)
    );

    spafc_pwm_fsm #(
        .MAG_W   (MAG_W),
        .PWM_BITS(PWM_BITS)
    ) u_pwm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .ref_ce   (ref_ce),
        .gate_end (gate_end),
        .new_brake(new_brake),
        .new_mag  (new_mag),
        .drive_hi (drive_hi),
        .drive_lo (drive_lo),
        .idle     (idle)
    );

endmodule

// File: rtl/spindle_afc_chk.sv
module spindle_afc_chk #(
    parameter int FRAME_DIV = 4,
    parameter int GATE_LEN  = 1000
) (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic frame_ce,
    input logic ref_ce,
    input logic gate_end,
    input logic drive_hi,
    input logic drive_lo,
    input logic idle
);

    localparam int GATE_CYC = FRAME_DIV * GATE_LEN;
    localparam int FC_W = $clog2(GATE_CYC) + 1;
    localparam logic [FC_W-1:0] FC_LAST = FC_W'(GATE_CYC - 1);

    logic [FC_W-1:0] fcnt;

    // frame enables seen since enable or since the last gate close
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fcnt <= '0;
        end else if (!en || gate_end) begin
            fcnt <= '0;
        end else if (frame_ce) begin
            fcnt <= fcnt + FC_W'(1);
        end
    end

    a_r1_gate_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        gate_end |-> (frame_ce && fcnt == FC_LAST));

    a_r9_one_level: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({drive_hi, drive_lo, idle}) == 1);

    a_r8_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> idle);

    a_r7_acquire_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |=> idle);

    a_r3_no_flip_to_hi: assert property (@(posedge clk) disable iff (!rst_n)
        drive_lo |=> !drive_hi);

    a_r4_no_flip_to_lo: assert property (@(posedge clk) disable iff (!rst_n)
        drive_hi |=> !drive_lo);

    a_r6_drive_onset: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(drive_hi) || $rose(drive_lo)) |-> ($past(ref_ce) || $past(gate_end)));

    always_comb begin
        if (!rst_n) begin
            a_r10_reset_idle: assert (idle && !drive_hi && !drive_lo);
        end
    end

endmodule

bind spindle_afc spindle_afc_chk #(
    .FRAME_DIV(FRAME_DIV),
    .GATE_LEN (GATE_LEN)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .frame_ce(frame_ce),
    .ref_ce  (ref_ce),
    .gate_end(gate_end),
    .drive_hi(drive_hi),
    .drive_lo(drive_lo),
    .idle    (idle)
);

// File: tb/spindle_afc_tb.sv
module spindle_afc_tb;

    localparam int CLK_PERIOD = 10;
    localparam int GATE_CYC   = 4000;
    localparam int NOM        = 1152;
    localparam int PERIOD_TK  = 128;
    localparam int WATCHDOG   = 120000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic frame_ce = 1'b0;
    logic ref_ce = 1'b0;
    logic drive_hi, drive_lo, idle;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [6:0] exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    spindle_afc u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .frame_ce(frame_ce),
        .ref_ce  (ref_ce),
        .drive_hi(drive_hi),
        .drive_lo(drive_lo),
        .idle    (idle)
    );

    // expected {brake, magnitude} for a gate count
    function automatic logic [6:0] duty_of(input int n);
        int e;
        e = n - NOM;
        if (e > 63) e = 63;
        if (e < -63) e = -63;
        return (e > 0) ? {1'b1, 6'(e)} : {1'b0, 6'(-e)};
    endfunction

    // one full gate with exactly n evenly spread reference ticks
    task automatic drive_gate(input int n, input bit push);
        int acc;
        acc = 0;
        if (push) exp_q.push_back(duty_of(n));
        for (int i = 0; i < GATE_CYC; i++) begin
            @(negedge clk);
            frame_ce = 1'b1;
            acc += n;
            if (acc >= GATE_CYC) begin
                acc -= GATE_CYC;
                ref_ce = 1'b1;
            end else begin
                ref_ce = 1'b0;
            end
        end
    endtask

    task automatic partial_gate(input int n, input int cycles);
        int acc;
        acc = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            frame_ce = 1'b1;
            acc += n;
            if (acc >= GATE_CYC) begin
                acc -= GATE_CYC;
                ref_ce = 1'b1;
            end else begin
                ref_ce = 1'b0;
            end
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // driver
    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        en = 1'b1;
        // run A: acquire, zero, fast, slow, limit, far fast, far slow, +/-1
        drive_gate(1152, 1'b1);   // R2 source for first periods
        drive_gate(1160, 1'b1);   // R3
        drive_gate(1140, 1'b1);   // R4
        drive_gate(1215, 1'b1);   // R5 limit
        drive_gate(1300, 1'b1);   // R5 saturate fast
        drive_gate(1000, 1'b1);   // R5 saturate slow
        drive_gate(1151, 1'b1);   // R4 one tick
        drive_gate(1153, 1'b1);   // R3 one tick
        drive_gate(1250, 1'b1);
        partial_gate(1152, 1500); // R8 drop enable mid gate
        @(negedge clk);
        en = 1'b0;
        frame_ce = 1'b0;
        ref_ce = 1'b0;
        repeat (30) @(negedge clk);
        en = 1'b1;
        // run B: R7 acquire again, then results
        drive_gate(1100, 1'b1);
        drive_gate(1152, 1'b1);
        drive_gate(1190, 1'b1);
        @(negedge clk);
        en = 1'b0;
        frame_ce = 1'b0;
        ref_ce = 1'b0;
        repeat (10) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

    // monitor and scoreboard
    int  fcount = 0;
    int  idx = 0;
    int  hi_cnt = 0;
    int  lo_cnt = 0;
    int  cyc = 0;
    bit  started = 1'b0;
    bit  en_prev = 1'b0;
    logic [6:0] cur_exp = '0;
    logic [6:0] per_exp = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic close_period();
        int eh, el;
        string req;
        eh = per_exp[6] ? 0 : int'(per_exp[5:0]);
        el = per_exp[6] ? int'(per_exp[5:0]) : 0;
        if (per_exp[5:0] == 6'd0) req = "R2";
        else if (per_exp[5:0] == 6'd63) req = "R5";
        else if (per_exp[6]) req = "R3";
        else req = "R4";
        // R6: one carrier period is 128 reference ticks
        check(hi_cnt == eh, req, "drive_hi ticks in period", hi_cnt, eh);
        check(lo_cnt == el, req, "drive_lo ticks in period", lo_cnt, el);
    endtask

    always @(negedge clk) begin
        #1;
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
            finish_run();
        end
        if (!rst_n) begin
            check(idle && !drive_hi && !drive_lo, "R10", "reset idle",
                  int'({drive_hi, drive_lo, idle}), 1);
        end else if (!en) begin
            if (!en_prev) begin
                check(idle && !drive_hi && !drive_lo, "R8", "disabled idle",
                      int'({drive_hi, drive_lo, idle}), 1);
            end
            started = 1'b0;
            fcount = 0;
            idx = 0;
            hi_cnt = 0;
            lo_cnt = 0;
        end else begin
            if (!started) begin
                check(idle && !drive_hi && !drive_lo, "R7", "acquire idle",
                      int'({drive_hi, drive_lo, idle}), 1);
            end
            if (frame_ce) begin
                // R1: gate closes on each 4000th frame enable
                if ((fcount % GATE_CYC) == GATE_CYC - 1) begin
                    if (exp_q.size() == 0) begin
                        checks++;
                        errors++;
                        $display("FAIL R1 gate without expected item actual=%0d expected=%0d", 0, 1);
                    end else begin
                        cur_exp = exp_q.pop_front();
                    end
                    if (!started) begin
                        started = 1'b1;
                        per_exp = cur_exp;
                        idx = 0;
                        hi_cnt = 0;
                        lo_cnt = 0;
                    end else if (ref_ce) begin
                        if (drive_hi) hi_cnt++;
                        if (drive_lo) lo_cnt++;
                        idx++;
                        if (idx == PERIOD_TK) begin
                            close_period();
                            per_exp = cur_exp;  // R6 forwarded result
                            idx = 0;
                            hi_cnt = 0;
                            lo_cnt = 0;
                        end
                    end
                    fcount++;
                end else begin
                    fcount++;
                    if (started && ref_ce) begin
                        if (drive_hi) hi_cnt++;
                        if (drive_lo) lo_cnt++;
                        idx++;
                        if (idx == PERIOD_TK) begin
                            close_period();
                            per_exp = cur_exp;
                            idx = 0;
                            hi_cnt = 0;
                            lo_cnt = 0;
                        end
                    end
                end
            end
        end
        en_prev = en;
    end

endmodule